// File: doc/BRIEF.md
# Two-Word Maskable Interrupt Controller

This block collects up to 63 interrupt requests, numbered 1 to 63, and presents the most urgent enabled one to a processor. Each request line is active-low and asynchronous. The block first synchronises each line. It then turns the line into a sticky pending flag. Depending on the line's class and a per-line select bit, the flag is set by a falling edge, by both edges, or by a held low level. Pending flags and enable flags are each packed into two 32-bit words. Sources are scattered across those words with a fixed, non-monotonic bit placement.

Software reaches the block through a single-cycle register port. The port holds the two enable words, the two pending words (write ones to clear), an edge-select word and a read-only vector word. A single interrupt output is raised whenever any enabled source is pending. The vector word reports the lowest-numbered enabled pending source in its top six bits, and reads zero when nothing is waiting.

Line classes are fixed by source number:
- Sources 19 to 25 are external lines. Each one is either falling-edge or active-low level, as chosen.
- Sources 48 to 63 are port lines. Each one is either falling-edge only or both-edges, as chosen.
- All other sources are active-low level.
- Input 0 is ignored.

Top module: `intc2w_top`

## Requirements
- R1: After reset, both enable words, both pending words, the edge-select word and the vector word read 0, and `irq_out` is 0.
- R2: Sources 1..15 occupy bit (16 − s) of the low word. Sources 32..47 occupy bit (63 − s) of the low word. Bit 0 of the low word is always 0.
- R3: Sources 16..31 occupy bit (31 − s) of the high word. Sources 48..63 occupy bit (s − 32) of the high word. The same placement applies to both the enable words and the pending words.
- R4: Writing a pending word clears every pending bit written as 1. Bits written as 0 are unchanged.
- R5: The vector word holds the selected source number in bits 31:26, with bits 25:0 zero. A value of 0 means no enabled source is pending. Writes to the vector word have no effect.
- R6: When several enabled sources are pending, the vector reports the lowest source number.
- R7: An enable bit of 1 enables its source. A disabled source still records pending but never drives the vector or `irq_out`.
- R8: For an external line s (19..25), edge-select bit (33 − s) chooses the trigger. A value of 1 means falling edge. A value of 0 means active-low level.
- R9: For a port line s (48..63), edge-select bit (s − 32) chooses the trigger. A value of 1 means falling edge only, so a rising edge never sets pending. A value of 0 means both edges.
- R10: A level-triggered source remains pending while its line is held low, even if a clear is written.
- R11: Sources outside the external and port ranges are always active-low level. Only edge-select bits 31:16 and 14:8 are stored; all other bits read 0.
- R12: A line change passes through a two-flop synchroniser. An edge raises pending on the third rising clock edge after the change, and not before.
- R13: `irq_out` is 1 exactly when at least one enabled source is pending.
- R14: Register word index (`reg_idx`): 0 high enable, 1 low enable, 2 high pending, 3 low pending, 4 edge-select, 5 vector. Reads return data on the clock edge after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_n | input | 64 | Active-low request lines, index = source number (bit 0 ignored) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Some properties are checked by assertions on every cycle:
- The output and the vector stay consistent with each other.
- The vector always names an enabled, pending source with no lower enabled pending source below it.
- A clear takes effect unless a new event arrives in the same cycle.
- A low level line stays pending.
- A falling-only port line ignores rising edges.

Other behaviours need the bench's directed scenarios:
- the scattered bit placement of each source;
- the exact three-edge synchroniser latency;
- the different triggers chosen by the edge-select bits;
- the ignored writes to the vector and to unused select bits.

// File: rtl/intc2w_pkg.sv
package intc2w_pkg;

    localparam int NUM_SRC    = 64;
    localparam int WORD_BITS  = 32;
    localparam int EXT_FIRST  = 19;
    localparam int EXT_LAST   = 25;
    localparam int PORT_FIRST = 48;
    localparam int PORT_LAST  = 63;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_INTERNAL,
        KIND_EXTERNAL,
        KIND_PORT
    } src_kind_e;

    typedef enum logic [2:0] {
        SEL_EN_HI   = 3'd0,
        SEL_EN_LO   = 3'd1,
        SEL_PEND_HI = 3'd2,
        SEL_PEND_LO = 3'd3,
        SEL_EDGE    = 3'd4,
        SEL_VECT    = 3'd5
    } reg_sel_e;

    // 1 when the source lives in the high word
    function automatic logic src_in_hi(input int s);
        return ((s >= 16 && s <= 31) || (s >= 48));
    endfunction

    // bit position of a source inside its word
    function automatic logic [4:0] src_pos(input int s);
        if (s >= 1 && s <= 15)       return 5'(16 - s);
        else if (s >= 16 && s <= 31) return 5'(31 - s);
        else if (s >= 32 && s <= 47) return 5'(63 - s);
        else if (s >= 48)            return 5'(s - 32);
        else                         return 5'd0;
    endfunction

    function automatic src_kind_e src_kind(input int s);
        if (s == 0)                                   return KIND_NONE;
        else if (s >= EXT_FIRST && s <= EXT_LAST)     return KIND_EXTERNAL;
        else if (s >= PORT_FIRST && s <= PORT_LAST)   return KIND_PORT;
        else                                          return KIND_INTERNAL;
    endfunction

    // edge-select bit used by a source (0 when the source has none)
    function automatic logic [4:0] esel_pos(input int s);
        if (s >= EXT_FIRST && s <= EXT_LAST)        return 5'(33 - s);
        else if (s >= PORT_FIRST && s <= PORT_LAST) return 5'(s - 32);
        else                                        return 5'd0;
    endfunction

    function automatic logic [WORD_BITS-1:0] esel_valid();
        logic [WORD_BITS-1:0] m;
        m = '0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (src_kind(s) == KIND_EXTERNAL || src_kind(s) == KIND_PORT)
                m[esel_pos(s)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/intc2w_sync.sv
module intc2w_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_n,
    output logic [WIDTH-1:0] line_sync,
    output logic [WIDTH-1:0] line_prev
);
    // stage STAGES holds the previous synchronised sample
    logic [WIDTH-1:0] chain [STAGES+1];

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= line_n;
    end

    for (genvar k = 1; k <= STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[k] <= '1;
            else        chain[k] <= chain[k-1];
        end
    end

    assign line_sync = chain[STAGES-1];
    assign line_prev = chain[STAGES];
endmodule

// File: rtl/intc2w_latch.sv
module intc2w_latch
    import intc2w_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int WW   = WORD_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] line_sync,
    input  logic [NSRC-1:0] line_prev,
    input  logic [WW-1:0]   edge_sel,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] set_evt;

    always_comb begin
        set_evt = '0;
        for (int s = 0; s < NSRC; s++) begin
            unique case (src_kind(s))
                KIND_NONE:     set_evt[s] = 1'b0;
                KIND_INTERNAL: set_evt[s] = ~line_sync[s];
                KIND_EXTERNAL: set_evt[s] = edge_sel[esel_pos(s)]
                                          ? (line_prev[s] & ~line_sync[s])
                                          : ~line_sync[s];
                KIND_PORT:     set_evt[s] = edge_sel[esel_pos(s)]
                                          ? (line_prev[s] & ~line_sync[s])
                                          : (line_prev[s] ^ line_sync[s]);
                default:       set_evt[s] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= set_evt | (pend & ~clr);
    end

    for (genvar s = 1; s < NSRC; s++) begin : g_chk
        localparam src_kind_e K = src_kind(s);
        localparam int        EP = int'(esel_pos(s));

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[s] && !set_evt[s]) |=> !pend[s]);  // R4

        if (K == KIND_INTERNAL) begin : g_int
            AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
                !line_sync[s] |=> pend[s]);  // R10
        end
        if (K == KIND_EXTERNAL) begin : g_ext
            AST_EXT_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_sel[EP] && !line_sync[s]) |=> pend[s]);  // R8
        end
        if (K == KIND_PORT) begin : g_port
            AST_PORT_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_sel[EP] && line_sync[s] && !line_prev[s] && !pend[s]) |=> !pend[s]);  // R9
        end
    end
endmodule

// File: rtl/intc2w_prio.sv
module intc2w_prio #(
    parameter int NSRC  = 64,
    parameter int VEC_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  active,
    output logic [VEC_W-1:0] vec
);
    // scan from the top so the lowest set source is the last written
    always_comb begin
        vec = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (active[s]) vec = VEC_W'(s);
        end
    end
endmodule

// File: rtl/intc2w_top.sv
module intc2w_top
    import intc2w_pkg::*;
#(
    parameter int NSRC        = NUM_SRC,
    parameter int WW          = WORD_BITS,
    parameter int IDX_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [WW-1:0]    reg_wdata,
    output logic [WW-1:0]    reg_rdata,
    output logic             irq_out
);
    localparam int          VEC_W   = $clog2(NSRC);
    localparam int          VEC_LSB = WW - VEC_W;
    localparam logic [WW-1:0] ESEL_MASK = esel_valid();

    logic [NSRC-1:0]  line_sync, line_prev;
    logic [NSRC-1:0]  pend, clr, en_src, active;
    logic [WW-1:0]    en_hi, en_lo, edge_sel;
    logic [WW-1:0]    pend_hi_w, pend_lo_w;
    logic [VEC_W-1:0] vec;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_idx);

    intc2w_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_n    (src_n),
        .line_sync (line_sync),
        .line_prev (line_prev)
    );

    intc2w_latch #(.NSRC(NSRC), .WW(WW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .line_prev (line_prev),
        .edge_sel  (edge_sel),
        .clr       (clr),
        .pend      (pend)
    );

    // word views and per-source decode
    always_comb begin
        en_src    = '0;
        clr       = '0;
        pend_hi_w = '0;
        pend_lo_w = '0;
        for (int s = 1; s < NSRC; s++) begin
            if (src_in_hi(s)) begin
                en_src[s]            = en_hi[src_pos(s)];
                pend_hi_w[src_pos(s)] = pend[s];
                clr[s] = reg_wr && (sel == SEL_PEND_HI) && reg_wdata[src_pos(s)];
            end else begin
                en_src[s]            = en_lo[src_pos(s)];
                pend_lo_w[src_pos(s)] = pend[s];
                clr[s] = reg_wr && (sel == SEL_PEND_LO) && reg_wdata[src_pos(s)];
            end
        end
    end

    assign active = pend & en_src;

    intc2w_prio #(.NSRC(NSRC), .VEC_W(VEC_W)) u_prio (
        .active (active),
        .vec    (vec)
    );

    assign irq_out = |active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_hi    <= '0;
            en_lo    <= '0;
            edge_sel <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                SEL_EN_HI: en_hi    <= reg_wdata;
                SEL_EN_LO: en_lo    <= reg_wdata;
                SEL_EDGE:  edge_sel <= reg_wdata & ESEL_MASK;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (sel)
                SEL_EN_HI:   reg_rdata <= en_hi;
                SEL_EN_LO:   reg_rdata <= en_lo;
                SEL_PEND_HI: reg_rdata <= pend_hi_w;
                SEL_PEND_LO: reg_rdata <= pend_lo_w;
                SEL_EDGE:    reg_rdata <= edge_sel;
                SEL_VECT:    reg_rdata <= {vec, {VEC_LSB{1'b0}}};
                default:     reg_rdata <= '0;
            endcase
        end
    end

    AST_IRQ_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (vec != '0));  // R13
    AST_VECTOR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> (en_src[vec] && pend[vec]));  // R7
    AST_VECTOR_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> ((active & ((NSRC'(1) << vec) - NSRC'(1))) == '0));  // R6
    AST_SOURCE0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0]);  // R2
endmodule

// File: tb/tb_intc2w_top.sv
module tb_intc2w_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src_n;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_idx;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq_out;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    intc2w_top dut (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic bit exp_hi(int s);
        return (s >= 16 && s <= 31) || s >= 48;
    endfunction
    function automatic int exp_bit(int s);
        if (s <= 15) return 16 - s;
        if (s <= 31) return 31 - s;
        if (s <= 47) return 63 - s;
        return s - 32;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_idx = idx;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic clean();
        @(negedge clk);
        src_n = '1;
        cyc(5);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            chk($sformatf("R1 reg %0d", i), d, 32'h0);
        end
        chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_map();
        int list[10] = '{1, 15, 16, 31, 32, 47, 48, 63, 10, 40};
        logic [31:0] hi, lo, ehi, elo;
        foreach (list[i]) begin
            int s = list[i];
            @(negedge clk); src_n[s] = 1'b0;
            cyc(5);
            rd(3'd2, hi);
            rd(3'd3, lo);
            ehi = exp_hi(s) ? (32'h1 << exp_bit(s)) : 32'h0;
            elo = exp_hi(s) ? 32'h0 : (32'h1 << exp_bit(s));
            chk($sformatf("R3 pend hi src %0d", s), hi, ehi);
            chk($sformatf("R2 pend lo src %0d", s), lo, elo);
            // enable only this source through the same placement
            wr(exp_hi(s) ? 3'd0 : 3'd1, 32'h1 << exp_bit(s));
            chk($sformatf("R7 irq src %0d", s), {31'h0, irq_out}, 32'h1);
            clean();
        end
    endtask

    task automatic t_clear();
        logic [31:0] d;
        // port 50, both edges: pulse low then high, pending sticks
        @(negedge clk); src_n[50] = 1'b0;
        cyc(3);
        @(negedge clk); src_n[50] = 1'b1;
        cyc(5);
        wr(3'd2, ~(32'h1 << 18));
        rd(3'd2, d);
        chk("R4 write zero keeps", d, 32'h1 << 18);
        wr(3'd2, 32'h1 << 18);
        rd(3'd2, d);
        chk("R4 write one clears", d, 32'h0);
        // internal level source 5 held low survives a clear
        @(negedge clk); src_n[5] = 1'b0;
        cyc(5);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d);
        chk("R10 level stays pending", d, 32'h1 << 11);
        chk("R11 internal is level", d, 32'h1 << 11);
        clean();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        @(negedge clk); src_n[40] = 1'b0; src_n[12] = 1'b0;
        cyc(5);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd5, d);
        chk("R6 lowest wins", d, 32'd12 << 26);
        chk("R13 irq high", {31'h0, irq_out}, 32'h1);
        wr(3'd1, ~(32'h1 << 4));
        rd(3'd5, d);
        chk("R7 masked skipped", d, 32'd40 << 26);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, d);
        chk("R5 vector read-only", d, 32'd40 << 26);
        wr(3'd1, 32'h0);
        rd(3'd5, d);
        chk("R5 vector zero when none", d, 32'h0);
        chk("R13 irq low", {31'h0, irq_out}, 32'h0);
        rd(3'd3, d);
        chk("R7 masked still pending", d, (32'h1 << 4) | (32'h1 << 23));
        clean();
    endtask

    task automatic t_ext();
        logic [31:0] d;
        wr(3'd4, 32'h1 << 13);      // source 20 falling edge
        @(negedge clk); src_n[20] = 1'b0;
        cyc(5);
        wr(3'd2, 32'h1 << 11);      // clear while held low
        rd(3'd2, d);
        chk("R8 falling edge not level", d, 32'h0);
        @(negedge clk); src_n[20] = 1'b1;
        cyc(5);
        @(negedge clk); src_n[20] = 1'b0;
        cyc(5);
        rd(3'd2, d);
        chk("R8 falling edge sets", d, 32'h1 << 11);
        wr(3'd4, 32'h0);            // level mode
        wr(3'd2, 32'h1 << 11);
        rd(3'd2, d);
        chk("R8 level stays", d, 32'h1 << 11);
        clean();
    endtask

    task automatic t_port();
        logic [31:0] d;
        wr(3'd4, 32'h1 << 23);      // source 55 falling only
        @(negedge clk); src_n[55] = 1'b0;
        cyc(5);
        rd(3'd2, d);
        chk("R9 falling sets", d, 32'h1 << 23);
        wr(3'd2, 32'h1 << 23);
        @(negedge clk); src_n[55] = 1'b1;
        cyc(5);
        rd(3'd2, d);
        chk("R9 rising ignored", d, 32'h0);
        wr(3'd4, 32'h0);            // both edges
        @(negedge clk); src_n[55] = 1'b0;
        cyc(5);
        wr(3'd2, 32'h1 << 23);
        rd(3'd2, d);
        chk("R9 held low not level", d, 32'h0);
        @(negedge clk); src_n[55] = 1'b1;
        cyc(5);
        rd(3'd2, d);
        chk("R9 rising sets in both mode", d, 32'h1 << 23);
        clean();
    endtask

    task automatic t_sync();
        wr(3'd0, 32'h1 << 28);      // enable source 60 only
        @(negedge clk); src_n[60] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R12 not before third edge", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R12 on third edge", {31'h0, irq_out}, 32'h1);
        clean();
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d);
        chk("R11 edge-select valid bits", d, 32'hFFFF_7F00);
        wr(3'd0, 32'hA5A5_0F0F);
        rd(3'd0, d);
        chk("R14 enable hi readback", d, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, d);
        chk("R14 enable lo readback", d, 32'h1234_5678);
        @(negedge clk); src_n[0] = 1'b0;
        cyc(5);
        rd(3'd3, d);
        chk("R2 input 0 ignored", d, 32'h0);
        clean();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src_n = '1; reg_wr = 0; reg_rd = 0; reg_idx = '0; reg_wdata = '0;
        cyc(4);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_map();
        t_clear();
        t_prio();
        t_ext();
        t_port();
        t_sync();
        t_regs();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule